// File: doc/BRIEF.md
# Graphic LCD Host Bus Interface

This block sits between a microcontroller's 8-bit parallel bus and the 512-byte display memory of a 64-column graphic LCD segment driver. It decodes a three-line chip select with mixed polarity, a register select, a read/write line and an enable strobe. Writes are taken on the falling edge of the enable strobe. Read data is presented while enable is high. The data bus is split into an input, an output and an output-enable, so that a pad ring or a bench can build the tri-state buffer.

The block keeps a 6-bit column counter, a 3-bit page register, a display-enable flag and a 6-bit display start line. The last two are passed on to the scan logic. Display memory is reached through a synchronous single-port interface: a registered address, a write strobe with data, and a read strobe whose data returns one clock later. A strap input chooses whether a column address lands in memory unchanged or mirrored, so that the panel can be wired in either direction.

Top module: `glcd_host_if`

## Requirements
- R1: The block is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. When it is not selected, `db_oe` is 0 and enable edges change nothing.
- R2: A write is accepted on the clock edge that sees `en` low after it was high. At that point `rw` must be 0 and the block must be selected. `rs`=1 marks display data and `rs`=0 marks an instruction.
- R3: While the block is selected with `rw`=1 and `en`=1, `db_oe` is 1. `db_o` then carries the read latch when `rs`=1, or the status byte when `rs`=0.
- R4: The instruction codes are as follows. `0011111d` sets the display flag to d. `01cccccc` loads the column. `10111ppp` loads the page. `11ssssss` loads the start line.
- R5: The status byte has busy in bit 7, display-off in bit 5 and reset-asserted in bit 4. All other bits are 0.
- R6: A data write stores the byte at memory address {page, mapped column}. The column then advances by one and wraps from 63 to 0.
- R7: A data read on a falling enable edge fetches the byte at the current column into the read latch and advances the column. The bus shows the byte from the previous read, so the first read after an address load is a dummy.
- R8: With `mirror`=1 the mapped column equals the column. With `mirror`=0 it equals 63 minus the column.
- R9: Every accepted write makes busy true for 2 clock cycles. A write whose falling edge arrives while busy is dropped: nothing is stored and the column does not move.
- R10: While `rst_n` is low, the display flag, start line, column and page are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| rs | input | 1 | 1 = display data, 0 = instruction/status |
| rw | input | 1 | 1 = read, 0 = write |
| en | input | 1 | Bus enable strobe |
| db_i | input | 8 | Data bus input |
| db_o | output | 8 | Data bus output |
| db_oe | output | 1 | Data bus output enable |
| mirror | input | 1 | Column mapping strap |
| ram_addr | output | 9 | Memory address {page, column} |
| ram_we | output | 1 | Memory write strobe |
| ram_re | output | 1 | Memory read strobe |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data, one cycle after `ram_re` |
| disp_on | output | 1 | Display enable flag |
| start_line | output | 6 | Display start line |

## Verification
The bench builds the block with its default parameters: a 6-bit column, a 3-bit page and a busy window of 2 cycles. These values make the 63-to-0 column wrap reachable within a few writes. With a 2-cycle window, two strobes sent back to back land the second falling edge inside busy, which exercises the dropped-write path. A short status read placed right after a write catches the busy bit while it is set.

// File: rtl/glcd_host_if.sv
module glcd_host_if #(
  parameter int COL_W    = 6,
  parameter int PAGE_W   = 3,
  parameter int BUSY_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b_n,
  input  logic                    cs_c,
  input  logic                    rs,
  input  logic                    rw,
  input  logic                    en,
  input  logic [7:0]              db_i,
  output logic [7:0]              db_o,
  output logic                    db_oe,
  input  logic                    mirror,
  output logic [PAGE_W+COL_W-1:0] ram_addr,
  output logic                    ram_we,
  output logic                    ram_re,
  output logic [7:0]              ram_wdata,
  input  logic [7:0]              ram_rdata,
  output logic                    disp_on,
  output logic [COL_W-1:0]        start_line
);

  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic              en_q, re_d;
  logic [BUSY_W-1:0] busy_cnt;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic [7:0]        rd_latch;

  wire sel   = ~cs_a_n & ~cs_b_n & cs_c;
  wire fall  = en_q & ~en;
  wire busy  = busy_cnt != '0;
  wire wr_ok = fall & sel & ~rw & ~busy;
  wire rd_ok = fall & sel & rw & rs;
  wire [COL_W-1:0] map_col = mirror ? col : ~col;

  assign db_oe = sel & rw & en;
  assign db_o  = rs ? rd_latch : {busy, 1'b0, ~disp_on, ~rst_n, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      re_d       <= 1'b0;
      busy_cnt   <= '0;
      col        <= '0;
      page       <= '0;
      rd_latch   <= '0;
      ram_addr   <= '0;
      ram_we     <= 1'b0;
      ram_re     <= 1'b0;
      ram_wdata  <= '0;
      disp_on    <= 1'b0;
      start_line <= '0;
    end else begin
      en_q   <= en;
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      re_d   <= ram_re;
      if (re_d) rd_latch <= ram_rdata;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (wr_ok) begin
        busy_cnt <= BUSY_W'(BUSY_CYC);
        if (rs) begin
          ram_we    <= 1'b1;
          ram_addr  <= {page, map_col};
          ram_wdata <= db_i;
          col       <= col + 1'b1;
        end else begin
          casez (db_i)
            8'b0011111?: disp_on    <= db_i[0];
            8'b01??????: col        <= db_i[COL_W-1:0];
            8'b10111???: page       <= db_i[PAGE_W-1:0];
            8'b11??????: start_line <= db_i[COL_W-1:0];
            default: ;
          endcase
        end
      end
      if (rd_ok) begin
        ram_re   <= 1'b1;
        ram_addr <= {page, map_col};
        col      <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/glcd_host_if_chk.sv
module glcd_host_if_chk #(
  parameter int ADDR_W = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_a_n,
  input logic       cs_b_n,
  input logic       cs_c,
  input logic       rs,
  input logic       rw,
  input logic       en,
  input logic       db_oe,
  input logic [7:0] db_o,
  input logic       ram_we,
  input logic       ram_re,
  input logic       busy
);

  p_oe_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n || cs_b_n || !cs_c) |-> !db_oe);

  p_we_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(en, 2) && !$past(en) && !$past(rw) && $past(rs)));

  p_oe_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_a_n && !cs_b_n && cs_c && rw && en) |-> db_oe);

  p_status_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe && !rs) |-> (db_o[6] == 1'b0 && db_o[3:0] == 4'h0));

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  p_busy_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

endmodule

bind glcd_host_if glcd_host_if_chk #(.ADDR_W(PAGE_W + COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c),
  .rs(rs), .rw(rw), .en(en), .db_oe(db_oe), .db_o(db_o),
  .ram_we(ram_we), .ram_re(ram_re), .busy(busy)
);

// File: tb/glcd_host_if_tb_top.sv
module glcd_host_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
  logic rs = 1'b0, rw = 1'b0, en = 1'b0, mirror = 1'b1;
  logic [7:0] db_i = 8'h00;
  logic [7:0] db_o, ram_wdata, ram_rdata;
  logic db_oe, ram_we, ram_re, disp_on;
  logic [8:0] ram_addr;
  logic [5:0] start_line;

  always #2.5 clk = ~clk;

  glcd_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c),
    .rs(rs), .rw(rw), .en(en), .db_i(db_i), .db_o(db_o), .db_oe(db_oe),
    .mirror(mirror), .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .disp_on(disp_on),
    .start_line(start_line)
  );

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  int n_chk = 0, n_err = 0;
  bit done = 0, rd_probe = 0;
  int         q_kind [$];
  logic [16:0] q_val [$];
  string      q_tag [$];
  logic [5:0] m_col = 0;
  logic [2:0] m_page = 0;
  logic [7:0] m_latch = 0;

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] map_addr();
    return {m_page, mirror ? m_col : ~m_col};
  endfunction

  function automatic void exp_wr(logic [7:0] d, string tag);
    logic [8:0] a = map_addr();
    q_kind.push_back(0); q_val.push_back({a, d}); q_tag.push_back(tag);
    exp_mem[a] = d;
    m_col = m_col + 1;
  endfunction

  function automatic void exp_rd(logic [7:0] d, string tag);
    q_kind.push_back(1); q_val.push_back({9'd0, d}); q_tag.push_back(tag);
  endfunction

  function automatic void exp_hiz(string tag);
    q_kind.push_back(2); q_val.push_back(17'd0); q_tag.push_back(tag);
  endfunction

  always @(negedge clk) begin
    if (ram_we) begin
      if (q_kind.size() == 0 || q_kind[0] != 0) chk("R6/R9 unexpected write", {ram_addr, ram_wdata}, 17'h1ffff);
      else begin
        chk(q_tag[0], {ram_addr, ram_wdata}, q_val[0]);
        void'(q_kind.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
      end
    end
    if (rd_probe) begin
      if (q_kind.size() == 0 || q_kind[0] == 0) chk("R3 unexpected probe", {8'd0, db_oe, db_o}, 17'h1ffff);
      else begin
        if (q_kind[0] == 1) chk(q_tag[0], {8'd0, db_oe, db_o}, {8'd0, 1'b1, q_val[0][7:0]});
        else chk(q_tag[0], {16'd0, db_oe}, 17'd0);
        void'(q_kind.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic select(bit on);
    cs_a_n = !on; cs_b_n = !on; cs_c = on;
  endtask

  task automatic bus_wr(bit r, logic [7:0] d, int gap = 4);
    @(posedge clk); #1;
    rw = 0; rs = r; db_i = d; en = 1;
    @(posedge clk); #1;
    en = 0;
    idle(gap);
  endtask

  task automatic bus_rd(bit r);
    @(posedge clk); #1;
    rw = 1; rs = r; en = 1; rd_probe = 1;
    @(posedge clk); #1;
    en = 0; rd_probe = 0;
    idle(4);
  endtask

  task automatic data_rd(string tag);
    exp_rd(m_latch, tag);
    m_latch = exp_mem[map_addr()];
    m_col = m_col + 1;
    bus_rd(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    idle(3); #1;
    chk("R10 reset flag", {16'd0, disp_on}, 17'd0);
    chk("R10 reset start", {11'd0, start_line}, 17'd0);
    select(1);
    exp_rd(8'h30, "R5 R10 status in reset");
    bus_rd(0);
    #1 rst_n = 1; idle(2);
    exp_rd(8'h20, "R5 status after reset");
    bus_rd(0);

    bus_wr(0, 8'h3F); #1;
    chk("R4 display on", {16'd0, disp_on}, 17'd1);
    exp_rd(8'h00, "R5 status on");
    bus_rd(0);
    bus_wr(0, 8'hC0 | 8'd21); #1;
    chk("R4 start line", {11'd0, start_line}, 17'd21);
    bus_wr(0, 8'h00); #1;
    chk("R4 unused code", {10'd0, disp_on, start_line}, {10'd0, 1'b1, 6'd21});

    bus_wr(0, 8'hB8 | 8'd5); m_page = 5;
    bus_wr(0, 8'h40 | 8'd62); m_col = 62;
    exp_wr(8'hA1, "R6 write col 62"); bus_wr(1, 8'hA1);
    exp_wr(8'hB2, "R6 write col 63"); bus_wr(1, 8'hB2);
    exp_wr(8'hC3, "R6 wrap to col 0"); bus_wr(1, 8'hC3);

    mirror = 0;
    bus_wr(0, 8'h40 | 8'd3); m_col = 3;
    exp_wr(8'hD4, "R8 mirrored col 3"); bus_wr(1, 8'hD4);
    mirror = 1;

    bus_wr(0, 8'h3E, 0);
    exp_rd(8'hA0, "R9 busy in status");
    bus_rd(0);
    exp_rd(8'h20, "R9 busy cleared");
    bus_rd(0);

    bus_wr(0, 8'h40 | 8'd10); m_col = 10;
    exp_wr(8'h11, "R9 first write"); bus_wr(1, 8'h11, 0);
    bus_wr(1, 8'h22);
    exp_wr(8'h33, "R9 dropped write left col"); bus_wr(1, 8'h33);

    select(0); cs_a_n = 0; cs_b_n = 0;
    bus_wr(1, 8'h44);
    exp_hiz("R1 cs_c low hi-z"); bus_rd(1);
    select(0); cs_c = 1; cs_b_n = 0;
    bus_wr(1, 8'h55);
    exp_hiz("R1 cs_a_n high hi-z"); bus_rd(0);
    select(0); cs_c = 1; cs_a_n = 0;
    bus_wr(0, 8'h3F); #1;
    chk("R1 ignored instruction", {16'd0, disp_on}, 17'd0);
    select(1);

    bus_wr(0, 8'h40 | 8'd62); m_col = 62;
    data_rd("R7 dummy read");
    data_rd("R7 read col 62");
    data_rd("R7 read col 63");
    data_rd("R7 read col 0");
    exp_wr(8'h66, "R7 col advanced by reads"); bus_wr(1, 8'h66);

    bus_wr(0, 8'h3F);
    bus_wr(0, 8'hC0 | 8'd9);
    #1 rst_n = 0; idle(1); #1;
    chk("R10 flag cleared", {16'd0, disp_on}, 17'd0);
    chk("R10 start cleared", {11'd0, start_line}, 17'd0);
    rst_n = 1; m_col = 0; m_page = 0; idle(2);
    exp_wr(8'h77, "R10 col and page zero"); bus_wr(1, 8'h77);

    idle(4);
    chk("R6 queue drained", 17'(q_kind.size()), 17'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule